// File: doc/BRIEF.md
# Instruction Fetch Buffer with Half-Word Aligner

The block sits between a processor's decode stage and a word-wide memory bus. It issues 32-bit word reads at word-aligned addresses, counts requests that the bus has granted but not yet answered, and keeps returned words in a two-entry fill buffer. From that buffer an aligner picks out the instruction that starts at the current half-word address. A 16-bit compressed instruction is any half word whose two low bits are not `2'b11`. A 32-bit instruction is any half word whose low bits are `2'b11`. The instruction goes to decode over a valid/ready handshake together with its address and two error flags.

A redirect (`branch_i` with a half-word-aligned `branch_addr_i`) restarts fetch at the target in the same cycle. It empties the fill buffer and drops any instruction that was waiting to be accepted. Every response that was still in flight at the redirect is discarded when it arrives. A bus error attached to a word marks the instruction drawn from it. When only the upper half of a word-crossing 32-bit instruction is bad, a second flag marks that. After decode accepts an erroneous instruction, the block stops fetching and delivering until the next redirect.

The control is a three-state machine. `ST_IDLE` is the state after reset, with no address known. `ST_RUN` means fetching and delivering. `ST_HALT` is entered after an accepted error. The transitions are `IDLE->RUN` on redirect, `RUN->RUN` on redirect, `RUN->HALT` when an error instruction is accepted, and `HALT->RUN` on redirect. A redirect takes priority over acceptance in the same cycle.

Top module: `fetch_align_buf`

## Requirements
- R1: Once `valid_o` is high it stays high until a cycle with `ready_i` high or `branch_i` high.
- R2: While an instruction is offered and neither accepted nor redirected, `addr_o` keeps its value into the next cycle.
- R3: Under the same pending condition, `err_o` keeps its value into the next cycle, and if `err_o` is high then `err_plus2_o` keeps its value too.
- R4: Under the same pending condition with `err_o` low, `rdata_o[15:0]` is stable; if `rdata_o[1:0]==2'b11`, then `rdata_o[31:16]` is stable as well.
- R5: `err_plus2_o` is high only together with `err_o`, and only when `rdata_o[1:0]==2'b11`. It is set exactly when a 32-bit instruction at an address with bit 1 set has a good first word and an erroneous second word.
- R6: An accepted error-free instruction moves `addr_o` forward by 2 if `rdata_o[1:0]!=2'b11` and by 4 otherwise. For a compressed instruction, `rdata_o[15:0]` holds the half word at `addr_o`; for an instruction at offset 0 with low bits `2'b11`, `rdata_o` holds the whole word.
- R7: A 32-bit instruction at an address with bit 1 set is assembled as `{upper word[15:0], lower word[31:16]}`. An instruction whose first half word comes from an erroneous word is offered with `err_o=1` and `err_plus2_o=0`.
- R8: After `branch_i`, the first instruction offered has address `{branch_addr_i[31:1],1'b0}`, and no data from responses in flight at the redirect is ever offered.
- R9: Bus requests carry `bus_addr_o` equal to the redirect word address, then rise by 4 per grant. The number of granted requests not yet answered never exceeds `MaxOutstanding` and always equals grants minus responses.
- R10: After an instruction with `err_o=1` is accepted, `valid_o` and `bus_req_o` stay low until the next `branch_i`.
- R11: After reset and before the first `branch_i`, `valid_o` and `bus_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| branch_i | input | 1 | Redirect fetch to `branch_addr_i` |
| branch_addr_i | input | 32 | Half-word-aligned redirect target |
| ready_i | input | 1 | Decode accepts the offered instruction |
| valid_o | output | 1 | An instruction is offered |
| rdata_o | output | 32 | Offered instruction (compressed ones in bits 15:0) |
| addr_o | output | 32 | Address of the offered instruction |
| err_o | output | 1 | Offered instruction is affected by a bus error |
| err_plus2_o | output | 1 | The error belongs to the upper half of a split 32-bit instruction |
| bus_req_o | output | 1 | Word read request |
| bus_addr_o | output | 32 | Word-aligned read address |
| bus_gnt_i | input | 1 | Bus accepts the request this cycle |
| bus_rvalid_i | input | 1 | Read response, in request order |
| bus_rdata_i | input | 32 | Response data |
| bus_err_i | input | 1 | Response carries an error |

## Verification
The bench builds the block with `FillDepth=2` and `MaxOutstanding=3`. That setting allows three requests to be in flight against only two buffer slots, so a redirect can leave more responses to discard than the buffer could hold. Response latency of up to three cycles, together with sparse grants and a stalling `ready_i`, makes word-crossing instructions wait on a missing second word. It also keeps pending offers waiting long enough to test the stability rules. Directed redirects land on a split instruction whose second word is bad, on a bad first word at offset 0, and on a compressed instruction at offset 2 inside a bad word.

// File: rtl/fab_pkg.sv
package fab_pkg;

    localparam int unsigned WordW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } fab_state_e;

    typedef struct packed {
        logic             err;
        logic [WordW-1:0] data;
    } fab_word_t;

endpackage

// File: rtl/fab_bus_track.sv
module fab_bus_track #(
    parameter int unsigned MaxOutstanding = 4,
    parameter int unsigned CntW           = $clog2(MaxOutstanding + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            issue_i,
    input  logic            resp_i,
    input  logic            flush_i,
    output logic [CntW-1:0] outst_o,
    output logic [CntW-1:0] live_o,
    output logic            keep_o
);
    logic [CntW-1:0] outst_q, outst_d;
    logic [CntW-1:0] drop_q, drop_d;

    always_comb begin
        outst_d = outst_q + CntW'(issue_i) - CntW'(resp_i);
        drop_d  = drop_q;
        if (flush_i) begin
            drop_d = outst_d;
        end else if (resp_i && (drop_q != '0)) begin
            drop_d = drop_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            outst_q <= '0;
            drop_q  <= '0;
        end else begin
            outst_q <= outst_d;
            drop_q  <= drop_d;
        end
    end

    assign outst_o = outst_q;
    assign live_o  = outst_q - drop_q;
    assign keep_o  = resp_i && !flush_i && (drop_q == '0);

endmodule

// File: rtl/fab_fill_buf.sv
module fab_fill_buf import fab_pkg::*; #(
    parameter int unsigned Depth = 2,
    parameter int unsigned CntW  = $clog2(Depth + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            flush_i,
    input  logic            push_i,
    input  fab_word_t       push_word_i,
    input  logic            pop_i,
    output fab_word_t       head_o,
    output fab_word_t       next_o,
    output logic [CntW-1:0] count_o
);
    localparam logic [CntW-1:0] DepthC = CntW'(Depth);

    fab_word_t       slot_q [Depth];
    fab_word_t       slot_d [Depth];
    logic [CntW-1:0] cnt_q, cnt_d;

    always_comb begin
        for (int i = 0; i < Depth; i++) begin
            slot_d[i] = slot_q[i];
        end
        cnt_d = cnt_q;
        if (flush_i) begin
            cnt_d = '0;
        end else begin
            if (pop_i && (cnt_q != '0)) begin
                for (int i = 0; i < Depth - 1; i++) begin
                    slot_d[i] = slot_q[i + 1];
                end
                cnt_d = cnt_q - 1'b1;
            end
            if (push_i && (cnt_d < DepthC)) begin
                for (int i = 0; i < Depth; i++) begin
                    if (CntW'(i) == cnt_d) begin
                        slot_d[i] = push_word_i;
                    end
                end
                cnt_d = cnt_d + 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < Depth; g++) begin : g_slot
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    slot_q[g] <= '0;
                end else begin
                    slot_q[g] <= slot_d[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign head_o  = slot_q[0];
    assign next_o  = slot_q[1];
    assign count_o = cnt_q;

endmodule

// File: rtl/fab_align.sv
module fab_align import fab_pkg::*; #(
    parameter int unsigned CntW = 2
) (
    input  fab_word_t        head_i,
    input  fab_word_t        next_i,
    input  logic [CntW-1:0]  fill_i,
    input  logic             off_i,
    output logic             valid_o,
    output logic [WordW-1:0] instr_o,
    output logic             err_o,
    output logic             plus2_o,
    output logic             big_o,
    output logic             pop_o
);
    logic [15:0] lo;
    logic        have0, have1;
    logic        unused_next_hi;

    assign lo             = off_i ? head_i.data[31:16] : head_i.data[15:0];
    assign big_o          = (lo[1:0] == 2'b11);
    assign have0          = (fill_i != '0);
    assign have1          = (fill_i >= CntW'(2));
    assign unused_next_hi = ^next_i.data[31:16];

    always_comb begin
        valid_o = have0;
        instr_o = {16'h0000, lo};
        err_o   = head_i.err;
        plus2_o = 1'b0;
        pop_o   = 1'b1;
        unique case ({off_i, big_o})
            2'b00: begin
                pop_o = 1'b0;
            end
            2'b01: begin
                instr_o = head_i.data;
            end
            2'b10: begin
                instr_o = {16'h0000, lo};
            end
            2'b11: begin
                if (!head_i.err) begin
                    valid_o = have1;
                    instr_o = {next_i.data[15:0], lo};
                    err_o   = next_i.err;
                    plus2_o = next_i.err;
                end
            end
        endcase
    end

endmodule

// File: rtl/fetch_align_buf.sv
module fetch_align_buf import fab_pkg::*; #(
    parameter int unsigned FillDepth      = 2,
    parameter int unsigned MaxOutstanding = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             branch_i,
    input  logic [WordW-1:0] branch_addr_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [WordW-1:0] rdata_o,
    output logic [WordW-1:0] addr_o,
    output logic             err_o,
    output logic             err_plus2_o,
    output logic             bus_req_o,
    output logic [WordW-1:0] bus_addr_o,
    input  logic             bus_gnt_i,
    input  logic             bus_rvalid_i,
    input  logic [WordW-1:0] bus_rdata_i,
    input  logic             bus_err_i
);
    localparam int unsigned FillCntW = $clog2(FillDepth + 1);
    localparam int unsigned OutCntW  = $clog2(MaxOutstanding + 1);
    localparam int unsigned SumW     = ((OutCntW > FillCntW) ? OutCntW : FillCntW) + 1;

    fab_state_e          state_q, state_d;
    logic [WordW-1:0]    pc_q, pc_d, faddr_q, faddr_d;
    logic                run, accept, err_taken, flush, issue, room, push, pop;
    logic [OutCntW-1:0]  outst_cnt, live_cnt;
    logic                resp_keep;
    logic [FillCntW-1:0] fill_cnt;
    fab_word_t           head_w, next_w, in_w;
    logic                al_valid, al_err, al_plus2, al_big, al_pop;
    logic [WordW-1:0]    al_instr;
    logic [SumW-1:0]     used;
    logic                unused_addr_lsb;

    assign unused_addr_lsb = branch_addr_i[0];

    fab_bus_track #(
        .MaxOutstanding(MaxOutstanding),
        .CntW          (OutCntW)
    ) u_track (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .issue_i(issue),
        .resp_i (bus_rvalid_i),
        .flush_i(flush),
        .outst_o(outst_cnt),
        .live_o (live_cnt),
        .keep_o (resp_keep)
    );

    assign in_w.err  = bus_err_i;
    assign in_w.data = bus_rdata_i;

    fab_fill_buf #(
        .Depth(FillDepth),
        .CntW (FillCntW)
    ) u_fill (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (flush),
        .push_i     (push),
        .push_word_i(in_w),
        .pop_i      (pop),
        .head_o     (head_w),
        .next_o     (next_w),
        .count_o    (fill_cnt)
    );

    fab_align #(
        .CntW(FillCntW)
    ) u_align (
        .head_i (head_w),
        .next_i (next_w),
        .fill_i (fill_cnt),
        .off_i  (pc_q[1]),
        .valid_o(al_valid),
        .instr_o(al_instr),
        .err_o  (al_err),
        .plus2_o(al_plus2),
        .big_o  (al_big),
        .pop_o  (al_pop)
    );

    assign run         = (state_q == ST_RUN);
    assign valid_o     = run && al_valid;
    assign rdata_o     = al_instr;
    assign addr_o      = pc_q;
    assign err_o       = al_err;
    assign err_plus2_o = al_plus2;
    assign bus_addr_o  = faddr_q;

    assign accept    = valid_o && ready_i && !branch_i;
    assign err_taken = accept && al_err;
    assign flush     = branch_i || err_taken;
    assign issue     = bus_req_o && bus_gnt_i;
    assign used      = SumW'(live_cnt) + SumW'(fill_cnt);
    assign room      = (used < SumW'(FillDepth));

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (branch_i) state_d = ST_RUN;
            ST_RUN: begin
                if (branch_i) begin
                    state_d = ST_RUN;
                end else if (err_taken) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: if (branch_i) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath control
    always_comb begin
        bus_req_o = run && room && (outst_cnt < OutCntW'(MaxOutstanding));
        push      = run && resp_keep;
        pop       = accept && !al_err && al_pop;
        pc_d      = pc_q;
        faddr_d   = faddr_q;
        if (branch_i) begin
            pc_d    = {branch_addr_i[WordW-1:1], 1'b0};
            faddr_d = {branch_addr_i[WordW-1:2], 2'b00};
        end else begin
            if (accept && !al_err) begin
                pc_d = pc_q + (al_big ? 32'd4 : 32'd2);
            end
            if (issue) begin
                faddr_d = faddr_q + 32'd4;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pc_q    <= '0;
            faddr_q <= '0;
        end else begin
            pc_q    <= pc_d;
            faddr_q <= faddr_d;
        end
    end

endmodule

// File: rtl/fab_chk.sv
module fab_chk #(
    parameter int unsigned MaxOutstanding = 4,
    parameter int unsigned CntW           = $clog2(MaxOutstanding + 1)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            branch_i,
    input logic            ready_i,
    input logic            valid_o,
    input logic [31:0]     rdata_o,
    input logic [31:0]     addr_o,
    input logic            err_o,
    input logic            err_plus2_o,
    input logic            bus_req_o,
    input logic            bus_gnt_i,
    input logic            bus_rvalid_i,
    input logic [CntW-1:0] outst_cnt
);
    logic [CntW-1:0] f_cnt;
    logic            f_halt;
    logic            f_pend;

    assign f_pend = valid_o && !ready_i && !branch_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_cnt  <= '0;
            f_halt <= 1'b0;
        end else begin
            f_cnt <= f_cnt + CntW'(bus_req_o && bus_gnt_i) - CntW'(bus_rvalid_i);
            if (branch_i) begin
                f_halt <= 1'b0;
            end else if (valid_o && ready_i && err_o) begin
                f_halt <= 1'b1;
            end
        end
    end

    // R1
    valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_pend |=> valid_o);
    // R2
    addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_pend |=> $stable(addr_o));
    // R3
    err_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_pend |=> $stable(err_o));
    // R3
    plus2_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_pend && err_o) |=> $stable(err_plus2_o));
    // R4
    lo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_pend && !err_o) |=> $stable(rdata_o[15:0]));
    // R4
    hi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_pend && !err_o && (rdata_o[1:0] == 2'b11)) |=> $stable(rdata_o[31:16]));
    // R5
    plus2_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && err_plus2_o) |-> (err_o && (rdata_o[1:0] == 2'b11)));
    // R6
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ready_i && !branch_i && !err_o) |=>
        (addr_o == $past(addr_o) + (($past(rdata_o[1:0]) == 2'b11) ? 32'd4 : 32'd2)));
    // R9
    resp_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rvalid_i |-> (f_cnt != '0));
    // R9
    outst_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (outst_cnt == f_cnt) && (outst_cnt <= CntW'(MaxOutstanding)));
    // R10
    halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_halt |-> (!valid_o && !bus_req_o));

endmodule

bind fetch_align_buf fab_chk #(
    .MaxOutstanding(MaxOutstanding)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .branch_i    (branch_i),
    .ready_i     (ready_i),
    .valid_o     (valid_o),
    .rdata_o     (rdata_o),
    .addr_o      (addr_o),
    .err_o       (err_o),
    .err_plus2_o (err_plus2_o),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_rvalid_i(bus_rvalid_i),
    .outst_cnt   (outst_cnt)
);

// File: tb/fetch_align_buf_tb.sv
`timescale 1ns/1ps
module fetch_align_buf_tb;
    localparam int MAX_OUT = 3;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic        branch_i, ready_i, bus_gnt_i, bus_rvalid_i, bus_err_i;
    logic [31:0] branch_addr_i, bus_rdata_i;
    logic        valid_o, err_o, err_plus2_o, bus_req_o;
    logic [31:0] rdata_o, addr_o, bus_addr_o;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, last_due = 0;
    int rmode = 0, gmode = 0, lat_max = 1;
    int n_deliv = 0, n_split = 0, n_plus2 = 0, n_err = 0;
    bit started = 0, halted = 0, hold_pend = 0;
    logic [31:0] m_pc = '0, m_fa = '0;
    logic [31:0] q_addr [$];
    int          q_due  [$];

    always #10 clk = ~clk;

    fetch_align_buf #(.FillDepth(2), .MaxOutstanding(MAX_OUT)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .branch_i(branch_i), .branch_addr_i(branch_addr_i),
        .ready_i(ready_i), .valid_o(valid_o), .rdata_o(rdata_o), .addr_o(addr_o),
        .err_o(err_o), .err_plus2_o(err_plus2_o), .bus_req_o(bus_req_o),
        .bus_addr_o(bus_addr_o), .bus_gnt_i(bus_gnt_i), .bus_rvalid_i(bus_rvalid_i),
        .bus_rdata_i(bus_rdata_i), .bus_err_i(bus_err_i));

    function automatic logic [15:0] half_at(logic [31:0] a);
        logic [15:0] v;
        if (a == 32'h2006) return 16'hBEE3;
        if (a == 32'h4006) return 16'h1230;
        if (a == 32'h1002) return 16'h5A5B;
        v = a[16:1] * 16'h9E3B + 16'h1234;
        return v ^ (v >> 7);
    endfunction

    function automatic logic [31:0] word_at(logic [31:0] a);
        return {half_at(a + 32'd2), half_at(a)};
    endfunction

    function automatic logic err_at(logic [31:0] a);
        return (a == 32'h2008) || (a == 32'h3000) || (a == 32'h4004);
    endfunction

    function automatic logic pick(int m);
        case (m)
            0: return 1'b1;
            1: return cyc[0];
            default: return ($urandom_range(0, 3) != 0);
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input logic br, input logic [31:0] tgt);
        logic [15:0] lo, hi;
        logic        big, e0, e1, fire;
        logic [31:0] pc2;
        int          due;
        @(negedge clk);
        cyc++;
        ready_i = pick(rmode);
        bus_gnt_i = pick(gmode);
        branch_i = br;
        branch_addr_i = tgt;
        if (q_addr.size() > 0 && q_due[0] <= cyc) begin
            bus_rvalid_i = 1'b1;
            bus_rdata_i = word_at(q_addr[0]);
            bus_err_i = err_at(q_addr[0]);
            void'(q_addr.pop_front());
            void'(q_due.pop_front());
        end else begin
            bus_rvalid_i = 1'b0;
            bus_rdata_i = '0;
            bus_err_i = 1'b0;
        end
        #1;
        lo  = half_at(m_pc);
        big = (lo[1:0] == 2'b11);
        pc2 = m_pc + 32'd2;
        hi  = half_at(pc2);
        e0  = err_at({m_pc[31:2], 2'b00});
        e1  = err_at({pc2[31:2], 2'b00});
        if (hold_pend) chk(valid_o, "R1 valid held", {31'b0, valid_o}, 32'd1);
        if (!started) begin
            chk(!valid_o && !bus_req_o, "R11 idle quiet", {30'b0, valid_o, bus_req_o}, 32'd0);
        end else if (halted) begin
            chk(!valid_o && !bus_req_o, "R10 halted quiet", {30'b0, valid_o, bus_req_o}, 32'd0);
        end else if (valid_o) begin
            chk(addr_o == m_pc, "R8 offered address", addr_o, m_pc);
            if (e0) begin
                chk(err_o && !err_plus2_o, "R7 first word error", {30'b0, err_o, err_plus2_o}, 32'd2);
            end else if (big && m_pc[1]) begin
                chk(err_o == e1 && err_plus2_o == e1, "R5 split error flags",
                    {30'b0, err_o, err_plus2_o}, {30'b0, e1, e1});
                chk(rdata_o[15:0] == lo, "R7 split low half", {16'b0, rdata_o[15:0]}, {16'b0, lo});
                if (!e1) chk(rdata_o[31:16] == hi, "R7 split high half", {16'b0, rdata_o[31:16]}, {16'b0, hi});
            end else begin
                chk(!err_o && !err_plus2_o, "R6 clean flags", {30'b0, err_o, err_plus2_o}, 32'd0);
                chk(rdata_o[15:0] == lo, "R6 low half", {16'b0, rdata_o[15:0]}, {16'b0, lo});
                if (big) chk(rdata_o[31:16] == hi, "R6 high half", {16'b0, rdata_o[31:16]}, {16'b0, hi});
            end
        end
        if (bus_req_o && bus_gnt_i) begin
            chk(bus_addr_o == m_fa, "R9 fetch address", bus_addr_o, m_fa);
            q_addr.push_back(m_fa);
            due = cyc + 1 + $urandom_range(0, lat_max - 1);
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            q_due.push_back(due);
            m_fa = m_fa + 32'd4;
            chk(q_addr.size() <= MAX_OUT, "R9 outstanding limit", q_addr.size(), MAX_OUT);
        end
        fire = valid_o && ready_i && !br;
        hold_pend = valid_o && !ready_i && !br;
        if (fire) begin
            n_deliv++;
            if (err_o) begin
                halted = 1;
                n_err++;
                if (err_plus2_o) n_plus2++;
            end else begin
                if (big && m_pc[1]) n_split++;
                m_pc = m_pc + (big ? 32'd4 : 32'd2);
            end
        end
        if (br) begin
            m_pc = {tgt[31:1], 1'b0};
            m_fa = {tgt[31:2], 2'b00};
            halted = 0;
            started = 1;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_ni = 1'b0;
        branch_i = 0; branch_addr_i = '0; ready_i = 0;
        bus_gnt_i = 0; bus_rvalid_i = 0; bus_rdata_i = '0; bus_err_i = 0;
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
        #1;
        chk(!valid_o && !bus_req_o, "R11 reset state", {30'b0, valid_o, bus_req_o}, 32'd0);
        run(5);
        // plain stream, fast bus
        step(1'b1, 32'h1000); run(60);
        // split start at offset 2, stalling decode, sparse grants, slow bus
        rmode = 1; gmode = 2; lat_max = 3;
        step(1'b1, 32'h1002); run(80);
        // split instruction whose upper word is bad
        step(1'b1, 32'h2006); run(25);
        chk(n_plus2 >= 1, "R5 upper half error seen", n_plus2, 1);
        chk(halted, "R10 halted after error", {31'b0, halted}, 32'd1);
        // bad first word, offset 0
        rmode = 2;
        step(1'b1, 32'h3000); run(25);
        // compressed at offset 2 of a bad word
        step(1'b1, 32'h4006); run(25);
        chk(n_err >= 3, "R7 errors delivered", n_err, 3);
        // redirect storm with slow responses in flight
        rmode = 0; gmode = 0; lat_max = 3;
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 32'h1100 + 32'(i * 6));
            if (i % 7 == 0) step(1'b1, 32'h1180 + 32'(i * 2));
            run(i % 5 + 1);
        end
        // mixed long run
        rmode = 2; gmode = 2;
        for (int i = 0; i < 2500; i++) begin
            if ($urandom_range(0, 40) == 0) step(1'b1, 32'h1000 + (32'($urandom_range(0, 2047)) << 1));
            else step(1'b0, 32'h0);
        end
        chk(n_split >= 5, "R7 split instructions delivered", n_split, 5);
        chk(n_deliv >= 300, "R6 deliveries made", n_deliv, 300);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule